// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a single-lane SPI host that runs one flash command at a time. Software programs a one-byte command code, a count of bytes to send after it and a count of bytes to read back. It loads the outgoing bytes into a 71-byte shared buffer and sets a start bit. The engine then pulls chip select low and sends the command code, followed by the outgoing bytes, most significant bit first. It then clocks in the requested number of reply bytes and places them in the same buffer, immediately after the outgoing bytes. Last, it releases chip select and drops its busy flag.

Software talks to the engine through a plain byte-wide register port. A write takes effect on the clock edge where `reg_we` is high. A read is combinational from `reg_addr`. The port never stalls, so it has no valid/ready handshake and applies no back-pressure. While a command runs, every write except the error-clear bit is dropped. Software is expected to poll the busy bit before it reprograms the engine.

The serial side uses SPI mode 0: SCK idles low and both ends sample on the rising edge. SCK toggles on every system clock, so its rate is half the clock. Each byte therefore takes 16 clocks.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sck` is 0, all four status bytes (0x4C..0x4F) read 0 and the command code (0x45) reads 0.
- R2: The command code (0x45), send count (0x48) and reply count (0x4B) read back what was last written while idle. Buffer slot j sits at address 0x80+j for j in 0..70 and reads back what was written.
- R3: Writing a byte with bit 7 set to 0x47 while idle, with send+reply ≤ 71, starts a command. `spi_cs_n` falls on that edge. The command code goes out first, MSB first, with SCK high for one clock and low for one clock per bit. A write to 0x47 with bit 7 clear starts nothing.
- R4: After the command code, buffer slots 0..send-1 go out in order. During the reply bytes the engine drives MOSI with 0.
- R5: MISO is sampled on each rising SCK. Reply byte i is stored in buffer slot send+i.
- R6: `spi_cs_n` stays low for exactly 16·(1+send+reply)+1 clocks. It stays high for at least two clocks after rising. SCK is low whenever `spi_cs_n` is high.
- R7: Status bit 31 (bit 7 of 0x4F) is 1 from the start edge until two clocks after `spi_cs_n` rises. A start write while busy is ignored.
- R8: A start write with send+reply > 71 is rejected: no chip select and no busy. It sets error bit 30 (bit 6 of 0x4F), which stays set until a write to 0x4F with bit 6 set clears it.
- R9: At the end of a command, status bits 7:0 hold 1+send+reply (bytes completed), bits 22:16 hold send (the buffer read pointer) and bits 14:8 hold send+reply (the buffer write pointer).
- R10: Writing 0x02 with bit 4 set (bit 20 of control word 0) while idle zeroes both buffer pointers.
- R11: Writes to the command code, the counts, the buffer and the pointer clear are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe for the current edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A wrong byte index or a slipped bit counter puts a wrong byte on MOSI within the 16 clocks of that byte. A scoreboarding slave catches it at the next byte boundary. A wrong length count moves the rising edge of `spi_cs_n` by a multiple of 16 clocks, so the chip-select low time shows it as soon as the command ends. Errors in the buffer-index mapping or in the pointers stay hidden until the command finishes. They then appear in the buffer readback and in status bytes 0x4C..0x4E. A missed accept or reject decision shows up in busy, the error bit and the chip-select count within a few clocks of the start write.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [7:0] OFS_CTRL_HI = 8'h02;  // byte 2 of control word 0
  localparam int         PTR_CLR_BIT = 4;      // bit 20 of control word 0
  localparam logic [7:0] OFS_OPCODE  = 8'h45;
  localparam logic [7:0] OFS_TRIG    = 8'h47;
  localparam int         TRIG_BIT    = 7;
  localparam logic [7:0] OFS_TXCNT   = 8'h48;
  localparam logic [7:0] OFS_RXCNT   = 8'h4B;
  localparam logic [7:0] OFS_STAT    = 8'h4C;
  localparam int         ERR_CLR_BIT = 6;      // bit 30 of status, in byte 0x4F
  localparam logic [7:0] BUF_BASE    = 8'h80;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_TAIL,
    ST_GAP
  } eng_state_e;
endpackage

// File: rtl/spi_cmd_buffer.sv
module spi_cmd_buffer #(
  parameter int DEPTH = 71,
  parameter int DW    = 8,
  localparam int BW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [BW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [BW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [BW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && (int'(waddr) < DEPTH)) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = (int'(raddr_a) < DEPTH) ? mem[raddr_a] : '0;
  assign rdata_b = (int'(raddr_b) < DEPTH) ? mem[raddr_b] : '0;
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int DW  = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_byte,
  input  logic          next_ok,
  input  logic [DW-1:0] next_byte,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          byte_end,
  output logic [DW-1:0] rx_byte
);
  logic          active, phase;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] txsh, rxsh;

  // second half of the last bit of a byte
  assign byte_end = active && phase && (bitcnt == CW'(DW - 1));
  assign mosi     = txsh[DW-1];
  assign rx_byte  = rxsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= 1'b0;
      bitcnt <= '0;
      txsh   <= '0;
      rxsh   <= '0;
      sck    <= 1'b0;
    end else if (load) begin
      active <= 1'b1;
      phase  <= 1'b0;
      bitcnt <= '0;
      txsh   <= load_byte;
      sck    <= 1'b0;
    end else if (active) begin
      if (!phase) begin
        sck   <= 1'b1;
        rxsh  <= {rxsh[DW-2:0], miso};
        phase <= 1'b1;
      end else begin
        sck   <= 1'b0;
        phase <= 1'b0;
        if (bitcnt == CW'(DW - 1)) begin
          bitcnt <= '0;
          if (next_ok) txsh <= next_byte;
          else         active <= 1'b0;
        end else begin
          bitcnt <= bitcnt + 1'b1;
          txsh   <= {txsh[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH = 71
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int DW = 8;
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH + 2);
  localparam int BW = $clog2(DEPTH);
  localparam int SW = DW + 1;

  eng_state_e     state_q;
  logic [DW-1:0]  opcode_q, txcnt_q, rxcnt_q, done_q;
  logic [IW-1:0]  byte_idx;
  logic [PW-1:0]  rd_ptr, wr_ptr;
  logic [1:0]     gap_q;
  logic           cs_q, err_flag, busy;
  logic [31:0]    status;

  logic [SW-1:0]  sum, total, idx_w;
  logic           sum_ok, wr_ok, in_buf, trig_hit, start, reject;
  logic           byte_end, next_ok, next_is_tx, rx_store, tx_done;
  logic [DW-1:0]  rx_byte, buf_sw_rd, buf_eng_rd, next_byte;
  logic [BW-1:0]  sw_idx, buf_waddr;
  logic           buf_we;
  logic [DW-1:0]  buf_wdata;

  assign busy     = (state_q != ST_IDLE);
  assign spi_cs_n = cs_q;

  assign sum      = {1'b0, txcnt_q} + {1'b0, rxcnt_q};
  assign sum_ok   = (sum <= SW'(DEPTH));
  assign total    = sum + 1'b1;
  assign idx_w    = SW'(byte_idx);

  assign wr_ok    = reg_we && !busy;
  assign in_buf   = (reg_addr >= BUF_BASE) && (int'(reg_addr) < int'(BUF_BASE) + DEPTH);
  assign sw_idx   = BW'(reg_addr - BUF_BASE);
  assign trig_hit = wr_ok && (reg_addr == OFS_TRIG) && reg_wdata[TRIG_BIT];
  assign start    = trig_hit && sum_ok;
  assign reject   = trig_hit && !sum_ok;

  // byte k of the frame (k = 0 is the command code) maps to buffer slot k-1
  assign next_ok    = (idx_w + 1'b1) < total;
  assign next_is_tx = idx_w < {1'b0, txcnt_q};
  assign next_byte  = next_is_tx ? buf_eng_rd : '0;
  assign rx_store   = (state_q == ST_RUN) && byte_end && (idx_w > {1'b0, txcnt_q});
  assign tx_done    = byte_end && (byte_idx != '0) && (idx_w <= {1'b0, txcnt_q});

  assign buf_we    = rx_store || (wr_ok && in_buf);
  assign buf_waddr = rx_store ? BW'(byte_idx - 1'b1) : sw_idx;
  assign buf_wdata = rx_store ? rx_byte : reg_wdata;

  spi_cmd_buffer #(.DEPTH(DEPTH), .DW(DW)) buf_i (
    .clk(clk), .rst_n(rst_n),
    .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr_a(sw_idx), .rdata_a(buf_sw_rd),
    .raddr_b(BW'(byte_idx)), .rdata_b(buf_eng_rd)
  );

  spi_cmd_shifter #(.DW(DW)) shf_i (
    .clk(clk), .rst_n(rst_n),
    .load(start), .load_byte(opcode_q),
    .next_ok(next_ok), .next_byte(next_byte),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
    .byte_end(byte_end), .rx_byte(rx_byte)
  );

  always_comb begin
    status = '0;
    status[31] = busy;
    status[30] = err_flag;
    status[16 +: PW] = rd_ptr;
    status[8 +: PW]  = wr_ptr;
    status[7:0]      = done_q;
  end

  always_comb begin
    if (reg_addr == OFS_OPCODE)              reg_rdata = opcode_q;
    else if (reg_addr == OFS_TXCNT)          reg_rdata = txcnt_q;
    else if (reg_addr == OFS_RXCNT)          reg_rdata = rxcnt_q;
    else if (reg_addr == OFS_STAT)           reg_rdata = status[7:0];
    else if (reg_addr == OFS_STAT + 8'd1)    reg_rdata = status[15:8];
    else if (reg_addr == OFS_STAT + 8'd2)    reg_rdata = status[23:16];
    else if (reg_addr == OFS_STAT + 8'd3)    reg_rdata = status[31:24];
    else if (in_buf)                         reg_rdata = buf_sw_rd;
    else                                     reg_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      opcode_q <= '0;
      txcnt_q  <= '0;
      rxcnt_q  <= '0;
      done_q   <= '0;
      byte_idx <= '0;
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      gap_q    <= '0;
      cs_q     <= 1'b1;
      err_flag <= 1'b0;
    end else begin
      if (reg_we && (reg_addr == OFS_STAT + 8'd3) && reg_wdata[ERR_CLR_BIT]) err_flag <= 1'b0;
      if (reject) err_flag <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (wr_ok) begin
            if (reg_addr == OFS_OPCODE) opcode_q <= reg_wdata;
            if (reg_addr == OFS_TXCNT)  txcnt_q  <= reg_wdata;
            if (reg_addr == OFS_RXCNT)  rxcnt_q  <= reg_wdata;
            if ((reg_addr == OFS_CTRL_HI) && reg_wdata[PTR_CLR_BIT]) begin
              rd_ptr <= '0;
              wr_ptr <= '0;
            end
          end
          if (start) begin
            state_q  <= ST_RUN;
            cs_q     <= 1'b0;
            byte_idx <= '0;
            done_q   <= '0;
            rd_ptr   <= '0;
            wr_ptr   <= PW'(txcnt_q);
          end
        end
        ST_RUN: begin
          if (byte_end) begin
            done_q   <= done_q + 1'b1;
            byte_idx <= byte_idx + 1'b1;
            if (tx_done)  rd_ptr <= PW'(byte_idx);
            if (rx_store) wr_ptr <= PW'(byte_idx);
            if (!next_ok) state_q <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          cs_q    <= 1'b1;
          gap_q   <= 2'd1;
          state_q <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_q == 2'd0) state_q <= ST_IDLE;
          else               gap_q   <= gap_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker #(
  parameter int DEPTH = 71,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sck,
  input logic          busy,
  input logic          err,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] wr_ptr
);
  // SCK is never high for two clocks in a row
  assert_sck_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sck |=> !sck);

  assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  assert_busy_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (cs_n && !busy));

  assert_ptr_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr <= wr_ptr) && (int'(wr_ptr) <= DEPTH));
endmodule

bind spi_cmd_engine spi_cmd_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck),
  .busy(busy), .err(err_flag), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
);

// File: tb/spi_cmd_engine_tb_top.sv
module spi_cmd_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       spi_sck, spi_cs_n, spi_mosi;
  logic       spi_miso = 1'b0;

  int checks = 0;
  int fails = 0;
  int cmd_id = 0;

  // slave model state
  logic [7:0] cap [0:79];
  int   cap_n = 0, bitpos = 0, bytek = 0, cs_falls = 0, cs_low_cnt = 0;
  logic [7:0] sh = 8'h00;
  logic cs_q = 1'b1, sck_q = 1'b0;
  logic [7:0] bufm [0:70];

  always #2 clk = ~clk;  // 250 MHz

  spi_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] resp(int c, int k);
    return 8'((c * 29 + k * 53 + 7) ^ (k << 3));
  endfunction

  // mode-0 slave: capture on rising SCK, change MISO after falling SCK
  always @(negedge clk) begin
    if (!spi_cs_n && cs_q) begin
      cs_falls++;
      cs_low_cnt = 1;
      bitpos = 0; bytek = 0; cap_n = 0;
      spi_miso = resp(cmd_id, 0) >> 7;
    end else if (!spi_cs_n) begin
      cs_low_cnt++;
    end
    if (!spi_cs_n && spi_sck && !sck_q) begin
      sh = {sh[6:0], spi_mosi};
      bitpos++;
      if (bitpos == 8 && bytek < 80) begin cap[bytek] = sh; cap_n++; end
    end
    if (!spi_cs_n && !spi_sck && sck_q) begin
      if (bitpos == 8) begin bitpos = 0; bytek++; end
      spi_miso = resp(cmd_id, bytek) >> (7 - bitpos);
    end
    cs_q = spi_cs_n;
    sck_q = spi_sck;
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int n = 0; n < 4000; n++) begin
      rd(8'h4F, s);
      if (!s[7]) return;
    end
  endtask

  task automatic run_cmd(input logic [7:0] op, input int tx, input int rx);
    logic [7:0] d;
    int f0, n, bad_tx, bad_z, bad_rx;
    n = 1 + tx + rx;
    wr(8'h45, op); wr(8'h48, 8'(tx)); wr(8'h4B, 8'(rx));
    for (int i = 0; i < tx; i++) begin
      bufm[i] = 8'($urandom);
      wr(8'h80 + 8'(i), bufm[i]);
    end
    cmd_id++;
    f0 = cs_falls;
    wr(8'h47, 8'h80);
    wait_idle();
    check("R7", "chip-select falls per start", cs_falls - f0, 1);
    check("R3", "bytes framed", cap_n, n);
    check("R3", "command code on MOSI", int'(cap[0]), int'(op));
    bad_tx = 0; bad_z = 0; bad_rx = 0;
    for (int i = 0; i < tx; i++) if (cap[1 + i] !== bufm[i]) bad_tx++;
    for (int i = 0; i < rx; i++) if (cap[1 + tx + i] !== 8'h00) bad_z++;
    check("R4", "send bytes mismatched", bad_tx, 0);
    check("R4", "nonzero MOSI reply bytes", bad_z, 0);
    for (int i = 0; i < rx; i++) begin
      bufm[tx + i] = resp(cmd_id, 1 + tx + i);
      rd(8'h80 + 8'(tx + i), d);
      if (d !== bufm[tx + i]) bad_rx++;
    end
    check("R5", "reply bytes misplaced", bad_rx, 0);
    check("R6", "chip-select low clocks", cs_low_cnt, 16 * n + 1);
    rd(8'h4C, d); check("R9", "done count", int'(d), n & 255);
    rd(8'h4D, d); check("R9", "write pointer", int'(d), tx + rx);
    rd(8'h4E, d); check("R9", "read pointer", int'(d), tx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected finished");
    report();
  end

  initial begin
    logic [7:0] d;
    int f0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1", "cs_n", int'(spi_cs_n), 1);
    check("R1", "sck", int'(spi_sck), 0);
    for (int b = 0; b < 4; b++) begin
      rd(8'h4C + 8'(b), d); check("R1", "status byte", int'(d), 0);
    end
    rd(8'h45, d); check("R1", "command code", int'(d), 0);

    // R2 readback
    wr(8'h45, 8'h9F); rd(8'h45, d); check("R2", "command code", int'(d), 8'h9F);
    wr(8'h48, 8'd5);  rd(8'h48, d); check("R2", "send count", int'(d), 5);
    wr(8'h4B, 8'd7);  rd(8'h4B, d); check("R2", "reply count", int'(d), 7);
    wr(8'hC6, 8'h11); rd(8'hC6, d); check("R2", "last buffer slot", int'(d), 8'h11);

    // R3 trigger with bit 7 clear
    f0 = cs_falls;
    wr(8'h47, 8'h7F);
    repeat (10) @(negedge clk);
    check("R3", "start without bit 7", cs_falls - f0, 0);
    rd(8'h4F, d); check("R3", "busy after bit-7-clear write", int'(d[7]), 0);

    // directed corners
    run_cmd(8'h05, 0, 0);
    run_cmd(8'h9F, 0, 3);
    run_cmd(8'h02, 71, 0);
    run_cmd(8'h0B, 0, 71);
    run_cmd(8'h03, 35, 36);

    // random commands
    for (int k = 0; k < 10; k++)
      run_cmd(8'($urandom), $urandom_range(0, 20), $urandom_range(0, 20));

    // R7 / R11: busy behaviour
    wr(8'hC6, 8'h11);
    wr(8'h45, 8'hA5); wr(8'h48, 8'd4); wr(8'h4B, 8'd4);
    cmd_id++;
    f0 = cs_falls;
    wr(8'h47, 8'h80);
    repeat (6) @(negedge clk);
    rd(8'h4F, d); check("R7", "busy while running", int'(d[7]), 1);
    wr(8'h45, 8'h3C);
    wr(8'hC6, 8'h99);
    wr(8'h48, 8'd9);
    wr(8'h47, 8'h80);
    wait_idle();
    repeat (40) @(negedge clk);
    check("R7", "start while busy ignored", cs_falls - f0, 1);
    check("R6", "chip-select low clocks", cs_low_cnt, 16 * 9 + 1);
    rd(8'h45, d); check("R11", "command code kept", int'(d), 8'hA5);
    rd(8'h48, d); check("R11", "send count kept", int'(d), 4);
    rd(8'hC6, d); check("R11", "buffer slot kept", int'(d), 8'h11);

    // R8 overflow reject
    wr(8'h48, 8'd40); wr(8'h4B, 8'd32);
    f0 = cs_falls;
    wr(8'h47, 8'h80);
    repeat (8) @(negedge clk);
    rd(8'h4F, d);
    check("R8", "error bit", int'(d[6]), 1);
    check("R8", "busy after reject", int'(d[7]), 0);
    check("R8", "chip-select after reject", cs_falls - f0, 0);
    run_cmd(8'h06, 2, 1);
    rd(8'h4F, d); check("R8", "error bit sticky", int'(d[6]), 1);
    wr(8'h4F, 8'h40);
    rd(8'h4F, d); check("R8", "error bit cleared", int'(d[6]), 0);

    // R10 pointer clear
    rd(8'h4D, d); check("R10", "write pointer before clear", int'(d), 3);
    wr(8'h02, 8'h10);
    rd(8'h4D, d); check("R10", "write pointer cleared", int'(d), 0);
    rd(8'h4E, d); check("R10", "read pointer cleared", int'(d), 0);

    report();
  end
endmodule